// File: doc/BRIEF.md
# Context-Saving Call/Return Stack

This block is the hardware return stack of a small controller core. It handles subroutine calls, conditional calls, software traps and returns. A push saves the whole execution context as one 23-bit entry: the return address (the address of the instruction after the call), the global interrupt-enable bit, the four ALU flags (Z, C, V, N) and the two register-bank select bits. A return pops that entry. It always reloads the program counter. Two operands decide whether the interrupt enable, the flags and the bank selection are also taken back. Twelve entries are shared by calls and traps.

The instruction decoder presents one command per cycle on plain control pins, together with the live context. The block answers one cycle later with single-cycle load strobes and the new values for the PC, the interrupt enable, the flags and the bank select. No command ever stalls, so the pins carry no valid/ready handshake and there is no back-pressure.

Traps form their target from an 8-bit interrupt base as the high byte and the 6-bit vector, zero-extended, as the low byte. Calls are either absolute, or relative with a signed 8-bit displacement added to the next-instruction address. Overflow and underflow each raise a one-cycle flag, and the offending operation is dropped.

Top module: `ctx_stack`

## Requirements
- R1: After reset the depth is 0 and every load strobe, `overflow_o` and `underflow_o` are low.
- R2: An absolute call pushes {cur_pc, cur_ie, cur_flags, cur_bank}. In the cycle after the request, `pc_load_o` is 1, `pc_next_o` equals `call_addr`, `depth_o` has risen by one and `ie_load_o` is 0.
- R3: A relative call (`call_rel`=1) targets cur_pc plus `call_addr[7:0]`, sign-extended to 16 bits and added modulo 2^16.
- R4: With `call_cond`=1, the call happens only when bit `call_bit` of `call_reg` equals `call_state`. Otherwise there is no strobe, no push and the depth is unchanged.
- R5: A trap pushes like a call and jumps to {int_base, 2'b00, trap_vec}. With `trap_clr_ie`=1 it also pulses `ie_load_o` with `ie_next_o`=0. With `trap_clr_ie`=0 it leaves `ie_load_o` low.
- R6: A return pops in last-in first-out order. It pulses `pc_load_o` with `pc_next_o` equal to the saved return address and lowers the depth by one.
- R7: The return mode `ret_ie_mode` works as follows. 0 keeps the interrupt enable (`ie_load_o`=0). 1 restores the saved bit. 2 sets it. 3 clears it. Modes 1 to 3 pulse `ie_load_o`.
- R8: With `ret_rf`=1 a return pulses `flags_load_o` and `bank_load_o`, carrying the saved flags {N,V,C,Z} and the saved bank bits {bankB,bankA}. With `ret_rf`=0 both strobes stay low.
- R9: With `ret_cond`=1, the return happens only when bit `ret_sel` of {stat_bits, cur_flags} equals `ret_state`. Selector values: 0=Z, 1=C, 2=V, 3=N, 4..7=stat_bits[0..3]. A false test pops nothing.
- R10: A push at depth 12 pulses `overflow_o`, gives no `pc_load_o`, keeps the depth at 12 and leaves the stored entries intact.
- R11: A return at depth 0 pulses `underflow_o`, gives no `pc_load_o` and keeps the depth at 0.
- R12: If a push request (call or trap) and a return arrive together, the push is taken and the return is dropped. If a trap and a call arrive together, the trap is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_en | input | 1 | Call request |
| call_rel | input | 1 | 1: relative call, 0: absolute |
| call_cond | input | 1 | Call is conditional on a register bit |
| call_addr | input | 16 | Absolute target, or displacement in [7:0] |
| call_reg | input | 8 | Register value tested by a conditional call |
| call_bit | input | 3 | Bit position tested |
| call_state | input | 1 | Required bit value |
| trap_en | input | 1 | Trap request |
| trap_vec | input | 6 | Trap vector 0..63 |
| trap_clr_ie | input | 1 | Trap clears interrupt enable |
| int_base | input | 8 | Interrupt base, high byte of trap target |
| ret_en | input | 1 | Return request |
| ret_cond | input | 1 | Return is conditional |
| ret_sel | input | 3 | Condition selector |
| ret_state | input | 1 | Required condition value |
| ret_ie_mode | input | 2 | Interrupt-enable handling on return |
| ret_rf | input | 1 | Restore flags and banks |
| cur_pc | input | 16 | Next-instruction address |
| cur_ie | input | 1 | Current interrupt enable |
| cur_flags | input | 4 | Current flags {N,V,C,Z} |
| stat_bits | input | 4 | Serial status bits for conditions |
| cur_bank | input | 2 | Current bank select {B,A} |
| pc_load_o | output | 1 | Load PC strobe |
| pc_next_o | output | 16 | New PC |
| ie_load_o | output | 1 | Load interrupt-enable strobe |
| ie_next_o | output | 1 | New interrupt enable |
| flags_load_o | output | 1 | Load flags strobe |
| flags_next_o | output | 4 | Restored flags |
| bank_load_o | output | 1 | Load bank select strobe |
| bank_next_o | output | 2 | Restored bank select |
| overflow_o | output | 1 | Push dropped, stack full |
| underflow_o | output | 1 | Pop dropped, stack empty |
| depth_o | output | 4 | Current number of entries |

## Verification
The bench aims at the full-stack boundary. A design that overwrote the top entry or wrapped its pointer would return a wrong address after a thirteenth push, or leave the depth wrong. It also checks the empty stack, where a faulty pop would load a garbage PC.

The sign of the relative displacement and the zero extension of the trap vector are checked with values whose top bits are set. A design that extended them the wrong way jumps to a distant address.

The four interrupt-enable modes and the flag/bank restore option are each checked against entries saved with distinct values, so a swapped mode or a missing restore shows up. Conditional operations are checked on both outcomes, and simultaneous requests confirm that the push wins.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;
  localparam int ADDR_W = 16;
  localparam int FLAG_W = 4;
  localparam int BANK_W = 2;
  localparam int VEC_W  = 6;
  localparam int BASE_W = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              ie;
    logic [FLAG_W-1:0] flags;
    logic [BANK_W-1:0] bank;
  } ctx_entry_t;

  typedef enum logic [1:0] {
    IE_KEEP    = 2'd0,
    IE_RESTORE = 2'd1,
    IE_SET     = 2'd2,
    IE_CLEAR   = 2'd3
  } ie_mode_e;
endpackage

// File: rtl/ctx_bit_test.sv
module ctx_bit_test #(
  parameter int W = 8,
  localparam int SEL_W = $clog2(W)
) (
  input  logic [W-1:0]     src_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             want_i,
  output logic             hit_o
);
  assign hit_o = (src_i[sel_i] == want_i);
endmodule

// File: rtl/ctx_target.sv
module ctx_target
  import ctx_stack_pkg::*;
#(
  parameter int DISP_W = 8
) (
  input  logic [ADDR_W-1:0] cur_pc_i,
  input  logic [ADDR_W-1:0] call_addr_i,
  input  logic              call_rel_i,
  input  logic [BASE_W-1:0] int_base_i,
  input  logic [VEC_W-1:0]  trap_vec_i,
  output logic [ADDR_W-1:0] call_tgt_o,
  output logic [ADDR_W-1:0] trap_tgt_o
);
  localparam int LOW_W = ADDR_W - BASE_W;
  logic [ADDR_W-1:0] disp_ext;

  // signed displacement widened to address width
  assign disp_ext   = {{(ADDR_W-DISP_W){call_addr_i[DISP_W-1]}}, call_addr_i[DISP_W-1:0]};
  assign call_tgt_o = call_rel_i ? (cur_pc_i + disp_ext) : call_addr_i;
  assign trap_tgt_o = {int_base_i, {(LOW_W-VEC_W){1'b0}}, trap_vec_i};
endmodule

// File: rtl/ctx_lifo.sv
module ctx_lifo
  import ctx_stack_pkg::*;
#(
  parameter int DEPTH = 12,
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  ctx_entry_t       wdata_i,
  output ctx_entry_t       rdata_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  ctx_entry_t       slot_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top_idx;
  logic             push_ok, pop_ok;

  assign full_o  = (cnt_q == FULL_CNT);
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !push_i && !empty_o;
  assign top_idx = cnt_q - 1'b1;
  assign rdata_o = empty_o ? '0 : slot_q[top_idx];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (push_ok) slot_q[cnt_q] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (push_ok) cnt_q <= cnt_q + 1'b1;
    else if (pop_ok)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/ctx_stack.sv
module ctx_stack
  import ctx_stack_pkg::*;
#(
  parameter int DEPTH = 12,
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_en,
  input  logic              call_rel,
  input  logic              call_cond,
  input  logic [ADDR_W-1:0] call_addr,
  input  logic [7:0]        call_reg,
  input  logic [2:0]        call_bit,
  input  logic              call_state,
  input  logic              trap_en,
  input  logic [VEC_W-1:0]  trap_vec,
  input  logic              trap_clr_ie,
  input  logic [BASE_W-1:0] int_base,
  input  logic              ret_en,
  input  logic              ret_cond,
  input  logic [2:0]        ret_sel,
  input  logic              ret_state,
  input  logic [1:0]        ret_ie_mode,
  input  logic              ret_rf,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic              cur_ie,
  input  logic [FLAG_W-1:0] cur_flags,
  input  logic [3:0]        stat_bits,
  input  logic [BANK_W-1:0] cur_bank,
  output logic              pc_load_o,
  output logic [ADDR_W-1:0] pc_next_o,
  output logic              ie_load_o,
  output logic              ie_next_o,
  output logic              flags_load_o,
  output logic [FLAG_W-1:0] flags_next_o,
  output logic              bank_load_o,
  output logic [BANK_W-1:0] bank_next_o,
  output logic              overflow_o,
  output logic              underflow_o,
  output logic [CNT_W-1:0]  depth_o
);
  logic              call_hit, ret_hit;
  logic              push_req, push_go, ret_go;
  logic [ADDR_W-1:0] call_tgt, trap_tgt;
  logic              full, empty;
  ctx_entry_t        push_entry, top_entry;
  ie_mode_e          ie_mode;

  ctx_bit_test #(.W(8)) u_call_test (
    .src_i(call_reg), .sel_i(call_bit), .want_i(call_state), .hit_o(call_hit)
  );

  ctx_bit_test #(.W(8)) u_ret_test (
    .src_i({stat_bits, cur_flags}), .sel_i(ret_sel), .want_i(ret_state), .hit_o(ret_hit)
  );

  ctx_target #(.DISP_W(8)) u_target (
    .cur_pc_i(cur_pc), .call_addr_i(call_addr), .call_rel_i(call_rel),
    .int_base_i(int_base), .trap_vec_i(trap_vec),
    .call_tgt_o(call_tgt), .trap_tgt_o(trap_tgt)
  );

  assign push_req   = call_en || trap_en;
  assign push_go    = trap_en || (call_en && (!call_cond || call_hit));
  assign ret_go     = ret_en && !push_req && (!ret_cond || ret_hit);
  assign push_entry = '{addr: cur_pc, ie: cur_ie, flags: cur_flags, bank: cur_bank};
  assign ie_mode    = ie_mode_e'(ret_ie_mode);

  ctx_lifo #(.DEPTH(DEPTH)) u_lifo (
    .clk(clk), .rst_n(rst_n), .push_i(push_go), .pop_i(ret_go),
    .wdata_i(push_entry), .rdata_o(top_entry),
    .full_o(full), .empty_o(empty), .cnt_o(depth_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_load_o    <= 1'b0;
      pc_next_o    <= '0;
      ie_load_o    <= 1'b0;
      ie_next_o    <= 1'b0;
      flags_load_o <= 1'b0;
      flags_next_o <= '0;
      bank_load_o  <= 1'b0;
      bank_next_o  <= '0;
      overflow_o   <= 1'b0;
      underflow_o  <= 1'b0;
    end else begin
      pc_load_o    <= 1'b0;
      ie_load_o    <= 1'b0;
      flags_load_o <= 1'b0;
      bank_load_o  <= 1'b0;
      overflow_o   <= 1'b0;
      underflow_o  <= 1'b0;
      if (push_go) begin
        if (full) begin
          overflow_o <= 1'b1;
        end else begin
          pc_load_o <= 1'b1;
          pc_next_o <= trap_en ? trap_tgt : call_tgt;
          if (trap_en && trap_clr_ie) begin
            ie_load_o <= 1'b1;
            ie_next_o <= 1'b0;
          end
        end
      end else if (ret_go) begin
        if (empty) begin
          underflow_o <= 1'b1;
        end else begin
          pc_load_o <= 1'b1;
          pc_next_o <= top_entry.addr;
          unique case (ie_mode)
            IE_KEEP:    ie_load_o <= 1'b0;
            IE_RESTORE: begin ie_load_o <= 1'b1; ie_next_o <= top_entry.ie; end
            IE_SET:     begin ie_load_o <= 1'b1; ie_next_o <= 1'b1; end
            IE_CLEAR:   begin ie_load_o <= 1'b1; ie_next_o <= 1'b0; end
          endcase
          if (ret_rf) begin
            flags_load_o <= 1'b1;
            flags_next_o <= top_entry.flags;
            bank_load_o  <= 1'b1;
            bank_next_o  <= top_entry.bank;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ctx_stack_chk.sv
module ctx_stack_chk #(
  parameter int DEPTH = 12,
  localparam int CNT_W = $clog2(DEPTH+1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pc_load_o,
  input logic             ie_load_o,
  input logic             ie_next_o,
  input logic             flags_load_o,
  input logic             bank_load_o,
  input logic             overflow_o,
  input logic             underflow_o,
  input logic [CNT_W-1:0] depth_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  a_r1_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= FULL_CNT);

  a_r10_overflow_full: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> depth_o == FULL_CNT);

  a_r11_underflow_empty: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> depth_o == '0);

  a_r12_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_load_o, overflow_o, underflow_o}));

  a_r8_restore_is_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_load_o || bank_load_o) |-> (int'(depth_o) + 1 == int'($past(depth_o))));

  a_r6_depth_step: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_o == $past(depth_o)) || (int'(depth_o) == int'($past(depth_o)) + 1)
    || (int'(depth_o) + 1 == int'($past(depth_o))));

  a_r5_ie_clear_with_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_load_o && !ie_next_o) |-> pc_load_o);
endmodule

bind ctx_stack ctx_stack_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_load_o(pc_load_o), .ie_load_o(ie_load_o),
  .ie_next_o(ie_next_o), .flags_load_o(flags_load_o), .bank_load_o(bank_load_o),
  .overflow_o(overflow_o), .underflow_o(underflow_o), .depth_o(depth_o)
);

// File: tb/ctx_stack_bench.sv
module ctx_stack_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic call_en, call_rel, call_cond, call_state;
  logic [15:0] call_addr;
  logic [7:0] call_reg;
  logic [2:0] call_bit;
  logic trap_en, trap_clr_ie;
  logic [5:0] trap_vec;
  logic [7:0] int_base;
  logic ret_en, ret_cond, ret_state, ret_rf;
  logic [2:0] ret_sel;
  logic [1:0] ret_ie_mode;
  logic [15:0] cur_pc;
  logic cur_ie;
  logic [3:0] cur_flags, stat_bits;
  logic [1:0] cur_bank;
  logic pc_load_o, ie_load_o, ie_next_o, flags_load_o, bank_load_o;
  logic overflow_o, underflow_o;
  logic [15:0] pc_next_o;
  logic [3:0] flags_next_o;
  logic [1:0] bank_next_o;
  logic [3:0] depth_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] m_addr [16];
  logic        m_ie   [16];
  logic [3:0]  m_fl   [16];
  logic [1:0]  m_bk   [16];
  int          m_depth = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_stack #(.DEPTH(DEPTH)) u_ctx_stack (
    .clk(clk), .rst_n(rst_n), .call_en(call_en), .call_rel(call_rel),
    .call_cond(call_cond), .call_addr(call_addr), .call_reg(call_reg),
    .call_bit(call_bit), .call_state(call_state), .trap_en(trap_en),
    .trap_vec(trap_vec), .trap_clr_ie(trap_clr_ie), .int_base(int_base),
    .ret_en(ret_en), .ret_cond(ret_cond), .ret_sel(ret_sel),
    .ret_state(ret_state), .ret_ie_mode(ret_ie_mode), .ret_rf(ret_rf),
    .cur_pc(cur_pc), .cur_ie(cur_ie), .cur_flags(cur_flags),
    .stat_bits(stat_bits), .cur_bank(cur_bank), .pc_load_o(pc_load_o),
    .pc_next_o(pc_next_o), .ie_load_o(ie_load_o), .ie_next_o(ie_next_o),
    .flags_load_o(flags_load_o), .flags_next_o(flags_next_o),
    .bank_load_o(bank_load_o), .bank_next_o(bank_next_o),
    .overflow_o(overflow_o), .underflow_o(underflow_o), .depth_o(depth_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic idle();
    call_en = 0; call_rel = 0; call_cond = 0; call_addr = 0; call_reg = 0;
    call_bit = 0; call_state = 0; trap_en = 0; trap_vec = 0; trap_clr_ie = 0;
    ret_en = 0; ret_cond = 0; ret_sel = 0; ret_state = 0; ret_ie_mode = 0; ret_rf = 0;
  endtask

  task automatic set_ctx(input logic [15:0] pc, input logic ie, input logic [3:0] fl,
                         input logic [1:0] bk);
    cur_pc = pc; cur_ie = ie; cur_flags = fl; cur_bank = bk;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // issue prepared push, check jump and model it
  task automatic do_push(input string req, input logic [15:0] tgt, input logic exp_ie_clr);
    step();
    chk({req, " pc_load"}, pc_load_o, 1);
    chk({req, " pc_next"}, pc_next_o, tgt);
    chk({req, " depth"}, depth_o, m_depth + 1);
    chk({req, " ie_load"}, ie_load_o, exp_ie_clr);
    if (exp_ie_clr) chk({req, " ie_next"}, ie_next_o, 0);
    m_addr[m_depth] = cur_pc; m_ie[m_depth] = cur_ie;
    m_fl[m_depth] = cur_flags; m_bk[m_depth] = cur_bank;
    m_depth++;
    idle();
  endtask

  task automatic do_pop(input string req, input logic [1:0] g, input logic rf);
    int t;
    t = m_depth - 1;
    ret_en = 1; ret_ie_mode = g; ret_rf = rf;
    step();
    chk({req, " R6 pc_load"}, pc_load_o, 1);
    chk({req, " R6 pc_next"}, pc_next_o, m_addr[t]);
    chk({req, " R6 depth"}, depth_o, t);
    chk({req, " R7 ie_load"}, ie_load_o, g != 0);
    if (g == 1) chk({req, " R7 ie restore"}, ie_next_o, m_ie[t]);
    if (g == 2) chk({req, " R7 ie set"}, ie_next_o, 1);
    if (g == 3) chk({req, " R7 ie clear"}, ie_next_o, 0);
    chk({req, " R8 flags_load"}, flags_load_o, rf);
    chk({req, " R8 bank_load"}, bank_load_o, rf);
    if (rf) begin
      chk({req, " R8 flags"}, flags_next_o, m_fl[t]);
      chk({req, " R8 bank"}, bank_next_o, m_bk[t]);
    end
    m_depth = t;
    idle();
  endtask

  task automatic t_reset();
    chk("R1 depth", depth_o, 0);
    chk("R1 strobes", {pc_load_o, ie_load_o, flags_load_o, bank_load_o}, 0);
    chk("R1 ovf/unf", {overflow_o, underflow_o}, 0);
  endtask

  task automatic t_call_abs();
    set_ctx(16'h1234, 1, 4'b1010, 2'b01);
    call_en = 1; call_addr = 16'hABCD;
    do_push("R2 absolute call", 16'hABCD, 0);
  endtask

  task automatic t_call_rel();
    set_ctx(16'h2000, 0, 4'b0101, 2'b10);
    call_en = 1; call_rel = 1; call_addr = 16'h55F0;
    do_push("R3 backward relative", 16'h1FF0, 0);
    set_ctx(16'hFFF0, 1, 4'b0011, 2'b11);
    call_en = 1; call_rel = 1; call_addr = 16'h007F;
    do_push("R3 forward wrap", 16'h006F, 0);
  endtask

  task automatic t_call_cond();
    set_ctx(16'h3000, 0, 4'b1100, 2'b00);
    call_en = 1; call_cond = 1; call_reg = 8'h04; call_bit = 3'd2; call_state = 0;
    step();
    chk("R4 false cond no jump", pc_load_o, 0);
    chk("R4 false cond depth", depth_o, m_depth);
    idle();
    call_en = 1; call_cond = 1; call_reg = 8'h80; call_bit = 3'd7; call_state = 1;
    call_addr = 16'h4444;
    do_push("R4 true cond", 16'h4444, 0);
  endtask

  task automatic t_trap();
    int_base = 8'hC3;
    set_ctx(16'h5000, 1, 4'b1001, 2'b01);
    trap_en = 1; trap_vec = 6'd45; trap_clr_ie = 1;
    do_push("R5 trap clr", 16'hC32D, 1);
    set_ctx(16'h5100, 0, 4'b0110, 2'b10);
    trap_en = 1; trap_vec = 6'd63; trap_clr_ie = 0;
    do_push("R5 trap keep", 16'hC33F, 0);
  endtask

  task automatic t_ret_cond();
    cur_flags = 4'b0111; stat_bits = 4'b0010;
    ret_en = 1; ret_cond = 1; ret_sel = 3'd3; ret_state = 1;
    step();
    chk("R9 false cond no pop", pc_load_o, 0);
    chk("R9 false cond depth", depth_o, m_depth);
    idle();
    ret_cond = 1; ret_sel = 3'd5; ret_state = 1;
    do_pop("R9 true cond", 2'd0, 0);
  endtask

  task automatic t_ret_modes();
    do_pop("mode1 rf1", 2'd1, 1);
    do_pop("mode2 rf0", 2'd2, 0);
    do_pop("mode3 rf1", 2'd3, 1);
    do_pop("mode1 rf0", 2'd1, 0);
    do_pop("mode0 rf1", 2'd0, 1);
  endtask

  task automatic t_underflow();
    ret_en = 1;
    step();
    chk("R11 underflow flag", underflow_o, 1);
    chk("R11 no jump", pc_load_o, 0);
    chk("R11 depth", depth_o, 0);
    idle();
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) begin
      set_ctx(16'h0100 + 16'(i), i[0], 4'(i), 2'(i));
      call_en = 1; call_addr = 16'h0900 + 16'(i);
      do_push("R10 fill", 16'h0900 + 16'(i), 0);
    end
    set_ctx(16'hDEAD, 1, 4'hF, 2'b11);
    call_en = 1; call_addr = 16'hBEEF;
    step();
    chk("R10 overflow flag", overflow_o, 1);
    chk("R10 no jump", pc_load_o, 0);
    chk("R10 depth held", depth_o, DEPTH);
    idle();
    do_pop("R10 top intact", 2'd1, 1);
  endtask

  task automatic t_priority();
    set_ctx(16'h7777, 0, 4'b0001, 2'b00);
    call_en = 1; call_addr = 16'h6000; ret_en = 1;
    do_push("R12 push beats return", 16'h6000, 0);
    do_pop("R12 make room", 2'd0, 0);
    set_ctx(16'h7800, 1, 4'b1000, 2'b01);
    int_base = 8'h12;
    call_en = 1; call_addr = 16'h6100; trap_en = 1; trap_vec = 6'd9;
    do_push("R12 trap beats call", 16'h1209, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    idle();
    set_ctx(0, 0, 0, 0);
    stat_bits = 0; int_base = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_call_abs();
    t_call_rel();
    t_call_cond();
    t_trap();
    t_ret_cond();
    t_ret_modes();
    t_underflow();
    t_overflow();
    t_priority();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule